// File: doc/BRIEF.md
# Power-up strap capture and configuration holder

This block turns a handful of shared pins into the initial configuration of a transceiver's control fields. While the hardware reset input is low, it samples the pins on every clock. When reset is released, the last sample is kept and the pins have no further effect. The sampled levels set five fields:
- a 5-bit station address, plus an isolate flag that is set only when the sampled address is zero
- a set of four advertised ability bits, plus a duplex bit, both chosen by one pin
- an LED mode selector
- an automatic crossover enable

Once reset has been released, a single-cycle write port can replace any field. A dedicated input clears the isolate flag. Nothing after reset can set the isolate flag again, and writing address zero does not set it either.

The pins are shared with functions that drive them later, so the block also produces an output enable. The enable stays low during reset and for one extra clock after the capture. This gives the pins time to stop being inputs before anything drives them.

On a board with no strap resistors fitted, the inputs default to address 1, the full advertisement set, LED mode 1 and crossover enabled.

Top module: `strap_cfg_top`

## Requirements
- R1: While `rst_n` is sampled low, `phy_addr` takes the value of `strap_addr` sampled at that clock edge. The value sampled at the last low edge is kept after `rst_n` rises.
- R2: The `isolate` output after reset equals 1 exactly when the last captured `strap_addr` is 0.
- R3: A write with `wr_sel` = 0 (address field) loads `wr_data[4:0]` into `phy_addr`. Writing the value 0 this way never sets `isolate`.
- R4: A captured `strap_adv` of 0 gives `adv_abil` = 4'b0101 and `full_duplex` = 0. A captured 1 gives `adv_abil` = 4'b1111 and `full_duplex` = 1. The bit order of `adv_abil` is bit0 10M half, bit1 10M full, bit2 100M half, bit3 100M full.
- R5: A captured `strap_led` of 1 gives `led_mode` = 1, and a captured 0 gives `led_mode` = 2. A write with `wr_sel` = 2 loads `wr_data[1:0]`, so any of the values 0 to 3 can be set.
- R6: `xover_en` equals the captured `strap_xover`. A write with `wr_sel` = 3 loads `wr_data[0]`.
- R7: Once `rst_n` is high, changes on any strap input leave every output unchanged.
- R8: After reset, `isolate_clr` = 1 clears `isolate` at the next edge. Nothing other than a reset capture sets `isolate`.
- R9: `pin_oe` is 0 while `rst_n` is low and for the first clock after `rst_n` rises. It is 1 from the second edge with `rst_n` high onward.
- R10: Writes while `rst_n` is low have no effect. Selector values 1 and 4 load `wr_data[3:0]` into `adv_abil` and `wr_data[0]` into `full_duplex`. Selector values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, sampled on the clock |
| strap_addr | input | 5 | Address strap pins |
| strap_adv | input | 1 | Advertisement set strap |
| strap_led | input | 1 | LED mode strap |
| strap_xover | input | 1 | Crossover enable strap |
| wr_en | input | 1 | Write strobe, one field per cycle |
| wr_sel | input | 3 | Field selector (0 addr, 1 abilities, 2 LED, 3 crossover, 4 duplex) |
| wr_data | input | 5 | Write data, low bits used per field |
| isolate_clr | input | 1 | Clears the isolate flag |
| phy_addr | output | 5 | Current station address |
| isolate | output | 1 | Isolate flag |
| adv_abil | output | 4 | Advertised abilities |
| full_duplex | output | 1 | Duplex control bit |
| led_mode | output | 2 | LED mode selector |
| xover_en | output | 1 | Automatic crossover enable |
| pin_oe | output | 1 | Output enable for the shared strap pins |

## Verification
Two events can fall on the same edge: the freeze edge, where capture stops, and a software write. The bench issues an address write, an address-zero write and an isolate clear in the very first cycle after `rst_n` rises, while the straps are also toggling. A behavioural model then decides which source owns each field after that edge. The model requires that the write wins, that the strap change is ignored, and that an isolate flag captured from address zero is removed only by the clear and never by the address write.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

   typedef enum logic [2:0] {
      SEL_ADDR   = 3'd0,
      SEL_ABIL   = 3'd1,
      SEL_LED    = 3'd2,
      SEL_XOVER  = 3'd3,
      SEL_DUPLEX = 3'd4
   } cfg_sel_e;

   localparam int ABIL_W = 4;

   // ability bit positions: 10 half, 10 full, 100 half, 100 full
   localparam int AB_10H  = 0;
   localparam int AB_10F  = 1;
   localparam int AB_100H = 2;
   localparam int AB_100F = 3;

   function automatic logic [ABIL_W-1:0] abil_from_strap(input logic s);
      logic [ABIL_W-1:0] v;
      v          = '0;
      v[AB_10H]  = 1'b1;
      v[AB_100H] = 1'b1;
      v[AB_10F]  = s;
      v[AB_100F] = s;
      return v;
   endfunction

endpackage

// File: rtl/strap_phase.sv
module strap_phase #(
   parameter int OE_HOLD = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic capture,
   output logic pin_oe
);

   assign capture = ~rst_n;

   generate
      if (OE_HOLD < 0) begin : g_bad_hold
         $error("strap_phase: OE_HOLD must not be negative");
      end

      if (OE_HOLD == 0) begin : g_direct
         logic oe_q;
         always_ff @(posedge clk) begin
            oe_q <= rst_n;
         end
         assign pin_oe = oe_q;
      end else begin : g_counted
         localparam int CNT_W = $clog2(OE_HOLD + 1);
         localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OE_HOLD);
         logic [CNT_W-1:0] cnt_q;
         logic             oe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               oe_q  <= 1'b0;
            end else begin
               if (cnt_q != CNT_END) begin
                  cnt_q <= cnt_q + 1'b1;
               end
               oe_q <= (cnt_q == CNT_END);
            end
         end
         assign pin_oe = oe_q;
      end
   endgenerate

endmodule

// File: rtl/cfg_field.sv
module cfg_field #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         capture,
   input  logic         wr_hit,
   input  logic [W-1:0] strap_val,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("cfg_field: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (capture) begin
         q_r <= strap_val;
      end else if (wr_hit) begin
         q_r <= din;
      end
   end

   assign q = q_r;

endmodule

// File: rtl/isolate_ctl.sv
module isolate_ctl #(
   parameter int ADDR_W   = 5,
   parameter int ISO_ADDR = 0
) (
   input  logic              clk,
   input  logic              capture,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic              clr,
   output logic              iso
);

   localparam logic [ADDR_W-1:0] ISO_MATCH = ADDR_W'(ISO_ADDR);

   generate
      if (ISO_ADDR < 0 || ISO_ADDR >= (1 << ADDR_W)) begin : g_bad_iso
         $error("isolate_ctl: ISO_ADDR out of address range");
      end
   endgenerate

   logic iso_r;

   // only the capture path may set; software may only clear
   always_ff @(posedge clk) begin
      if (capture) begin
         iso_r <= (strap_addr == ISO_MATCH);
      end else if (clr) begin
         iso_r <= 1'b0;
      end
   end

   assign iso = iso_r;

endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
   import strap_cfg_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int LED_W       = 2,
   parameter int DATA_W      = 5,
   parameter int OE_HOLD     = 1,
   parameter int LED_STRAP_H = 1,
   parameter int LED_STRAP_L = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic              strap_adv,
   input  logic              strap_led,
   input  logic              strap_xover,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              isolate_clr,
   output logic [ADDR_W-1:0] phy_addr,
   output logic              isolate,
   output logic [ABIL_W-1:0] adv_abil,
   output logic              full_duplex,
   output logic [LED_W-1:0]  led_mode,
   output logic              xover_en,
   output logic              pin_oe
);

   localparam logic [LED_W-1:0] LED_HI = LED_W'(LED_STRAP_H);
   localparam logic [LED_W-1:0] LED_LO = LED_W'(LED_STRAP_L);

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("strap_cfg_top: ADDR_W must fit in DATA_W");
      end
      if (ABIL_W > DATA_W || LED_W > DATA_W) begin : g_bad_data
         $error("strap_cfg_top: DATA_W too narrow for a field");
      end
      if (LED_STRAP_H >= (1 << LED_W) || LED_STRAP_L >= (1 << LED_W)) begin : g_bad_led
         $error("strap_cfg_top: strapped LED modes exceed LED_W");
      end
   endgenerate

   logic capture;
   logic wr_ok;

   strap_phase #(.OE_HOLD(OE_HOLD)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .pin_oe  (pin_oe)
   );

   assign wr_ok = wr_en & ~capture;

   logic hit_addr, hit_abil, hit_led, hit_xover, hit_dup;
   always_comb begin
      hit_addr  = wr_ok && (wr_sel == SEL_ADDR);
      hit_abil  = wr_ok && (wr_sel == SEL_ABIL);
      hit_led   = wr_ok && (wr_sel == SEL_LED);
      hit_xover = wr_ok && (wr_sel == SEL_XOVER);
      hit_dup   = wr_ok && (wr_sel == SEL_DUPLEX);
   end

   logic [LED_W-1:0]  led_strap_val;
   logic [ABIL_W-1:0] abil_strap_val;
   always_comb begin
      led_strap_val  = strap_led ? LED_HI : LED_LO;
      abil_strap_val = abil_from_strap(strap_adv);
   end

   cfg_field #(.W(ADDR_W)) u_addr (
      .clk       (clk),
      .capture   (capture),
      .wr_hit    (hit_addr),
      .strap_val (strap_addr),
      .din       (wr_data[ADDR_W-1:0]),
      .q         (phy_addr)
   );

   cfg_field #(.W(ABIL_W)) u_abil (
      .clk       (clk),
      .capture   (capture),
      .wr_hit    (hit_abil),
      .strap_val (abil_strap_val),
      .din       (wr_data[ABIL_W-1:0]),
      .q         (adv_abil)
   );

   cfg_field #(.W(1)) u_dup (
      .clk       (clk),
      .capture   (capture),
      .wr_hit    (hit_dup),
      .strap_val (strap_adv),
      .din       (wr_data[0]),
      .q         (full_duplex)
   );

   cfg_field #(.W(LED_W)) u_led (
      .clk       (clk),
      .capture   (capture),
      .wr_hit    (hit_led),
      .strap_val (led_strap_val),
      .din       (wr_data[LED_W-1:0]),
      .q         (led_mode)
   );

   cfg_field #(.W(1)) u_xover (
      .clk       (clk),
      .capture   (capture),
      .wr_hit    (hit_xover),
      .strap_val (strap_xover),
      .din       (wr_data[0]),
      .q         (xover_en)
   );

   isolate_ctl #(.ADDR_W(ADDR_W), .ISO_ADDR(0)) u_iso (
      .clk        (clk),
      .capture    (capture),
      .strap_addr (strap_addr),
      .clr        (isolate_clr),
      .iso        (isolate)
   );

endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk #(
   parameter int ADDR_W = 5,
   parameter int LED_W  = 2,
   parameter int DATA_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              isolate_clr,
   input logic [ADDR_W-1:0] phy_addr,
   input logic              isolate,
   input logic [3:0]        adv_abil,
   input logic              full_duplex,
   input logic [LED_W-1:0]  led_mode,
   input logic              xover_en,
   input logic              pin_oe
);

   // R3: address write lands one edge later
   p_addr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0) |=> (phy_addr == $past(wr_data[ADDR_W-1:0])));

   // R8: isolate cannot rise once reset has been released
   p_iso_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> !$rose(isolate));

   // R8: clear takes effect at the next edge
   p_iso_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      isolate_clr |=> !isolate);

   // R9: enable low in the first cycle after release
   p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(rst_n, 2)) |-> !pin_oe);

   // R9: enable high once two edges have seen reset high
   p_oe_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> pin_oe);

   // R4: right after release the abilities and duplex form a strapped pair
   p_abil_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> ((adv_abil == 4'b1111 && full_duplex) ||
                         (adv_abil == 4'b0101 && !full_duplex)));

   // R5: a strapped LED mode is 1 or 2
   p_led_strap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (led_mode == LED_W'(1) || led_mode == LED_W'(2)));

   // R7: crossover holds when not written after release
   p_xover_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !(wr_en && wr_sel == 3'd3)) |=> $stable(xover_en));

endmodule

bind strap_cfg_top strap_cfg_chk #(
   .ADDR_W (ADDR_W),
   .LED_W  (LED_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .isolate_clr (isolate_clr),
   .phy_addr    (phy_addr),
   .isolate     (isolate),
   .adv_abil    (adv_abil),
   .full_duplex (full_duplex),
   .led_mode    (led_mode),
   .xover_en    (xover_en),
   .pin_oe      (pin_oe)
);

// File: tb/strap_cfg_top_test.sv
module strap_cfg_top_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] strap_addr = 5'd1;
   logic       strap_adv = 1'b1;
   logic       strap_led = 1'b1;
   logic       strap_xover = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [4:0] wr_data = 5'd0;
   logic       isolate_clr = 1'b0;

   logic [4:0] phy_addr;
   logic       isolate;
   logic [3:0] adv_abil;
   logic       full_duplex;
   logic [1:0] led_mode;
   logic       xover_en;
   logic       pin_oe;

   int checks = 0;
   int failures = 0;
   bit checking = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   strap_cfg_top uut (
      .clk (clk), .rst_n (rst_n),
      .strap_addr (strap_addr), .strap_adv (strap_adv),
      .strap_led (strap_led), .strap_xover (strap_xover),
      .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
      .isolate_clr (isolate_clr),
      .phy_addr (phy_addr), .isolate (isolate), .adv_abil (adv_abil),
      .full_duplex (full_duplex), .led_mode (led_mode),
      .xover_en (xover_en), .pin_oe (pin_oe)
   );

   // behavioural reference model
   int  m_addr, m_abil, m_dup, m_led, m_xov, m_iso, m_oe;
   int  high_edges = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_addr = strap_addr;
         m_iso  = (strap_addr == 0) ? 1 : 0;
         m_abil = strap_adv ? 15 : 5;
         m_dup  = strap_adv;
         m_led  = strap_led ? 1 : 2;
         m_xov  = strap_xover;
         high_edges = 0;
      end else begin
         if (wr_en) begin
            case (wr_sel)
               3'd0: m_addr = wr_data;
               3'd1: m_abil = wr_data % 16;
               3'd2: m_led  = wr_data % 4;
               3'd3: m_xov  = wr_data % 2;
               3'd4: m_dup  = wr_data % 2;
               default: ;
            endcase
         end
         if (isolate_clr) m_iso = 0;
         high_edges = high_edges + 1;
      end
      m_oe = (high_edges >= 2) ? 1 : 0;
      checking = 1'b1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking && !done) begin
         chk("R1/R3 phy_addr", int'(phy_addr), m_addr);
         chk("R2/R8 isolate", int'(isolate), m_iso);
         chk("R4/R10 adv_abil", int'(adv_abil), m_abil);
         chk("R4/R10 full_duplex", int'(full_duplex), m_dup);
         chk("R5 led_mode", int'(led_mode), m_led);
         chk("R6 xover_en", int'(xover_en), m_xov);
         chk("R9 pin_oe", int'(pin_oe), m_oe);
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input int sel, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 5'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic enter_reset(input int a, input bit adv, input bit led, input bit xo);
      @(negedge clk);
      rst_n = 1'b0;
      strap_addr = 5'(a); strap_adv = adv; strap_led = led; strap_xover = xo;
   endtask

   initial begin
      // R1: default straps, with a change during reset that must be tracked
      strap_addr = 5'd7;
      cyc(2);
      strap_addr = 5'd1;
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 5'd20; // R10: ignored in reset
      cyc(2);
      wr_en = 1'b0;
      rst_n = 1'b1;
      // R7: straps wiggle after release
      strap_addr = 5'd0; strap_adv = 1'b0; strap_led = 1'b0; strap_xover = 1'b0;
      cyc(4);
      // R3: write address 0, isolate stays 0
      wr(0, 0);
      cyc(1);
      // R5: any LED mode by write
      wr(2, 3); wr(2, 0);
      // R6, R10 writes
      wr(3, 0); wr(1, 3); wr(4, 0);
      wr(5, 31); wr(7, 21); wr(6, 9);
      cyc(2);

      // R2/R4/R5/R6: strapped zero address and low straps
      enter_reset(0, 1'b0, 1'b0, 1'b0);
      cyc(3);
      rst_n = 1'b1;
      // freeze edge collision: address write plus clear
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 5'd9; isolate_clr = 1'b1;
      strap_addr = 5'd3;
      cyc(1);
      wr_en = 1'b0; isolate_clr = 1'b0;
      cyc(3);

      // R3/R8: isolate held through address-zero write, then cleared
      enter_reset(0, 1'b1, 1'b1, 1'b1);
      cyc(2);
      rst_n = 1'b1;
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 5'd0;
      cyc(1);
      wr_en = 1'b0;
      cyc(2);
      wr(0, 0);
      @(negedge clk); isolate_clr = 1'b1;
      @(negedge clk); isolate_clr = 1'b0;
      wr(0, 0);
      cyc(3);

      // mixed stimulus with occasional resets
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         rst_n       = ($urandom_range(0, 19) != 0);
         strap_addr  = 5'($urandom_range(0, 3) == 0 ? 0 : $urandom_range(0, 31));
         strap_adv   = 1'($urandom_range(0, 1));
         strap_led   = 1'($urandom_range(0, 1));
         strap_xover = 1'($urandom_range(0, 1));
         wr_en       = ($urandom_range(0, 2) == 0);
         wr_sel      = 3'($urandom_range(0, 7));
         wr_data     = 5'($urandom_range(0, 31));
         isolate_clr = ($urandom_range(0, 7) == 0);
      end
      @(negedge clk);
      rst_n = 1'b1; wr_en = 1'b0; isolate_clr = 1'b0;
      cyc(4);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule